// File: doc/BRIEF.md
# Squelching Two-Stage Output Clock Divider

This block sits behind a fast oscillator and turns its clock into the output clock. The oscillator clock passes through two dividers in series. The first divides by an even integer taken directly from its field. The second divides by a power of two chosen through a three-bit code. The divided clock always has a 50% duty cycle. It is low for the first half of each period and high for the second half.

The block drives a tristate output pad as an enable/level pair. While the output is live, the pad follows the divided clock. While it is squelched, the pad shows a selectable idle state: high impedance, driven low or driven high. Several conditions squelch the output: software clears the enable, a calibration is running, or the divider settings are illegal. A setting is illegal when a field is malformed or when the overall ratio falls outside a programmable window. The output only switches between live and squelched at the end of a divided-clock period, so the pad never shows a shortened pulse. New divider settings also take effect only at a period end, and the counters restart cleanly from that point.

All logic runs in the oscillator clock domain. Every control pin is sampled directly. There are no streaming interfaces, so there is no back-pressure.

Top module: `clkdiv_squelch`

## Requirements
- R1: With legal settings, `div_clk` has a period of `hs_ratio * 2^k` cycles of `clk`, where k is `ls_code` (000=/1, 001=/2, 010=/4, 011=/8, 100=/16, 101=/32). The high and low phases are each half of that period. While the output is live, `pad_oe`=1 and `pad_lvl` equals `div_clk`.
- R2: `hs_ratio` is legal only when it is even and lies between 10 and 1022 inclusive. Any other value squelches the output and holds `div_clk` low.
- R3: `ls_code` values 110 and 111 are reserved. Either value squelches the output and holds `div_clk` low.
- R4: The product `hs_ratio * 2^k` must lie within [`grade_min`, `grade_max`], with both limits inclusive. A product outside that window squelches the output and holds `div_clk` low.
- R5: While squelched, the pad shows the state selected by `idle_mode`. Bit 1 set alone (10) gives `pad_oe`=1, `pad_lvl`=0. Bit 0 set alone (01) gives `pad_oe`=1, `pad_lvl`=1. Code 00 and the reserved code 11 both give `pad_oe`=0, `pad_lvl`=0.
- R6: The output is squelched while `out_en`=0 or `cal_busy`=1. It becomes live again once `out_en`=1, `cal_busy`=0 and the settings are legal.
- R7: Switching between live and squelched happens only at the end of a divided-clock period. A live high phase always runs its full length. A newly live output always starts with a full low phase.
- R8: A change to `hs_ratio` or `ls_code` does not affect the period in progress. The new values apply from the next period end, which starts with a full low phase at the new ratio.
- R9: While `rst_n`=0, `div_clk`=0 and the pad shows the idle state selected by `idle_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_ratio | input | 10 | First-stage divide ratio (even, 10..1022) |
| ls_code | input | 3 | Second-stage power-of-two code |
| out_en | input | 1 | Output enable requested by software |
| idle_mode | input | 2 | Pad state while squelched |
| grade_min | input | 16 | Smallest allowed overall ratio |
| grade_max | input | 16 | Largest allowed overall ratio |
| cal_busy | input | 1 | Calibration in progress; squelches the output |
| div_clk | output | 1 | Divided clock, before gating |
| pad_oe | output | 1 | Pad driver enable (0 = high impedance) |
| pad_lvl | output | 1 | Level driven on the pad |

## Verification
A divider reload and a squelch decision can both fall on the same period end, because both are taken in the cycle where the divided clock falls. The bench provokes this by changing `hs_ratio` and clearing `out_en` in one cycle, partway through a high phase. It then checks that the high phase still runs its full old length and that the pad goes to high impedance right after it. After re-enabling the output, it checks that the first low and high phases already use the new ratio.

// File: rtl/odiv_pkg.sv
package odiv_pkg;
  // Pad state while squelched: bit 1 alone drives low, bit 0 alone drives high.
  typedef enum logic [1:0] {
    IDLE_Z   = 2'b00,
    IDLE_HI  = 2'b01,
    IDLE_LO  = 2'b10,
    IDLE_RSV = 2'b11
  } idle_e;
endpackage

// File: rtl/odiv_cfg_check.sv
module odiv_cfg_check #(
  parameter int HS_W     = 10,
  parameter int LS_W     = 3,
  parameter int LS_CODES = 6,
  parameter int HS_MIN   = 10,
  parameter int HS_MAX   = 1022,
  parameter int PROD_W   = 16
) (
  input  logic [HS_W-1:0]   hs,
  input  logic [LS_W-1:0]   ls,
  input  logic [PROD_W-1:0] lim_lo,
  input  logic [PROD_W-1:0] lim_hi,
  output logic              ok
);
  logic [PROD_W-1:0] hs_w;
  logic [PROD_W-1:0] prod;
  logic              hs_ok;
  logic              ls_ok;

  always_comb begin
    hs_w  = PROD_W'(hs);
    prod  = hs_w << ls;
    hs_ok = !hs[0] && (hs >= HS_W'(HS_MIN)) && (hs <= HS_W'(HS_MAX));
    ls_ok = ls < LS_W'(LS_CODES);
    ok    = hs_ok && ls_ok && (prod >= lim_lo) && (prod <= lim_hi);
  end
endmodule

// File: rtl/odiv_counter.sv
module odiv_counter #(
  parameter int HS_W     = 10,
  parameter int LS_W     = 3,
  parameter int LS_CODES = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HS_W-1:0] hs_in,
  input  logic [LS_W-1:0] ls_in,
  input  logic            in_ok,
  output logic            ld,
  output logic            div_q,
  output logic            act_run,
  output logic [HS_W-1:0] act_hs,
  output logic [LS_W-1:0] act_ls
);
  localparam int HALF_W = HS_W - 1;
  localparam int LCNT_W = (LS_CODES > 1) ? LS_CODES - 1 : 1;

  logic [HALF_W-1:0] hcnt;
  logic [HALF_W-1:0] half;
  logic [LCNT_W-1:0] lcnt;
  logic [LCNT_W-1:0] lim;
  logic              tick;
  logic              tgl;

  // Second-stage terminal count: 2^k - 1 as a mask of k ones.
  for (genvar g = 0; g < LCNT_W; g++) begin : g_lim
    assign lim[g] = (act_ls > LS_W'(g));
  end

  always_comb begin
    half = act_hs[HS_W-1:1];
    tick = act_run && (hcnt == half - 1'b1);
    tgl  = tick && (lcnt == lim);
    // Reload at the end of a high phase, or every cycle while halted.
    ld   = (tgl && div_q) || !act_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hs  <= '0;
      act_ls  <= '0;
      act_run <= 1'b0;
      hcnt    <= '0;
      lcnt    <= '0;
      div_q   <= 1'b0;
    end else if (ld) begin
      act_hs  <= hs_in;
      act_ls  <= ls_in;
      act_run <= in_ok;
      hcnt    <= '0;
      lcnt    <= '0;
      div_q   <= 1'b0;
    end else if (act_run) begin
      hcnt <= tick ? '0 : hcnt + 1'b1;
      if (tick) lcnt <= (lcnt == lim) ? '0 : lcnt + 1'b1;
      if (tgl) div_q <= ~div_q;
    end
  end
endmodule

// File: rtl/odiv_pad_gate.sv
module odiv_pad_gate
  import odiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       want,
  input  logic       div_q,
  input  logic [1:0] idle_mode,
  output logic       live,
  output logic       pad_oe,
  output logic       pad_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   live <= 1'b0;
    else if (upd) live <= want;
  end

  always_comb begin
    if (live) begin
      pad_oe  = 1'b1;
      pad_lvl = div_q;
    end else begin
      unique case (idle_e'(idle_mode))
        IDLE_LO: begin pad_oe = 1'b1; pad_lvl = 1'b0; end
        IDLE_HI: begin pad_oe = 1'b1; pad_lvl = 1'b1; end
        default: begin pad_oe = 1'b0; pad_lvl = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/clkdiv_squelch.sv
module clkdiv_squelch #(
  parameter int HS_W     = 10,
  parameter int LS_W     = 3,
  parameter int LS_CODES = 6,
  parameter int HS_MIN   = 10,
  parameter int HS_MAX   = 1022,
  parameter int PROD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HS_W-1:0]   hs_ratio,
  input  logic [LS_W-1:0]   ls_code,
  input  logic              out_en,
  input  logic [1:0]        idle_mode,
  input  logic [PROD_W-1:0] grade_min,
  input  logic [PROD_W-1:0] grade_max,
  input  logic              cal_busy,
  output logic              div_clk,
  output logic              pad_oe,
  output logic              pad_lvl
);
  logic            in_ok;
  logic            ld;
  logic            act_run;
  logic [HS_W-1:0] act_hs;
  logic [LS_W-1:0] act_ls;
  logic            live;
  logic            want;

  odiv_cfg_check #(
    .HS_W(HS_W), .LS_W(LS_W), .LS_CODES(LS_CODES),
    .HS_MIN(HS_MIN), .HS_MAX(HS_MAX), .PROD_W(PROD_W)
  ) u_check (
    .hs(hs_ratio), .ls(ls_code), .lim_lo(grade_min), .lim_hi(grade_max), .ok(in_ok)
  );

  odiv_counter #(
    .HS_W(HS_W), .LS_W(LS_W), .LS_CODES(LS_CODES)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_ratio), .ls_in(ls_code), .in_ok(in_ok),
    .ld(ld), .div_q(div_clk), .act_run(act_run), .act_hs(act_hs), .act_ls(act_ls)
  );

  // Gate decision is taken only at reload points (period end or halted).
  assign want = out_en && !cal_busy && in_ok;

  odiv_pad_gate u_gate (
    .clk(clk), .rst_n(rst_n), .upd(ld), .want(want), .div_q(div_clk),
    .idle_mode(idle_mode), .live(live), .pad_oe(pad_oe), .pad_lvl(pad_lvl)
  );
endmodule

// File: rtl/odiv_sva.sv
module odiv_sva #(
  parameter int HS_W     = 10,
  parameter int LS_W     = 3,
  parameter int LS_CODES = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            div_clk,
  input logic            pad_oe,
  input logic            pad_lvl,
  input logic [1:0]      idle_mode,
  input logic            act_run,
  input logic [HS_W-1:0] act_hs,
  input logic [LS_W-1:0] act_ls
);
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pad_oe && pad_lvl && div_clk) && div_clk && $stable(idle_mode)) |-> (pad_oe && pad_lvl)); // R7

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pad_oe) && $stable(idle_mode)) |-> !pad_lvl); // R7

  AST_DRIVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && (pad_lvl != div_clk)) |-> (idle_mode == {~pad_lvl, pad_lvl})); // R5

  AST_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |=> div_clk); // R1

  AST_LOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_clk) |=> !div_clk); // R8

  AST_LEGAL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> (act_run && !act_hs[0] && (act_ls < LS_W'(LS_CODES)))); // R3
endmodule

bind clkdiv_squelch odiv_sva #(.HS_W(HS_W), .LS_W(LS_W), .LS_CODES(LS_CODES)) u_sva (
  .clk(clk), .rst_n(rst_n), .div_clk(div_clk), .pad_oe(pad_oe), .pad_lvl(pad_lvl),
  .idle_mode(idle_mode), .act_run(act_run), .act_hs(act_hs), .act_ls(act_ls)
);

// File: tb/tb_clkdiv_squelch.sv
module tb_clkdiv_squelch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  hs_ratio;
  logic [2:0]  ls_code;
  logic        out_en;
  logic [1:0]  idle_mode;
  logic [15:0] grade_min;
  logic [15:0] grade_max;
  logic        cal_busy;
  logic        div_clk;
  logic        pad_oe;
  logic        pad_lvl;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkdiv_squelch dut (
    .clk(clk), .rst_n(rst_n), .hs_ratio(hs_ratio), .ls_code(ls_code), .out_en(out_en),
    .idle_mode(idle_mode), .grade_min(grade_min), .grade_max(grade_max),
    .cal_busy(cal_busy), .div_clk(div_clk), .pad_oe(pad_oe), .pad_lvl(pad_lvl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Skip to a fresh period end, then time one high and one low phase.
  task automatic measure(output int hi, output int lo);
    while (!div_clk) step();
    while (div_clk) step();
    while (!div_clk) step();
    hi = 0;
    while (div_clk) begin hi++; step(); end
    lo = 0;
    while (!div_clk) begin lo++; step(); end
  endtask

  task automatic idle_exp(output bit eoe, output bit elvl);
    eoe  = (idle_mode == 2'b10) || (idle_mode == 2'b01);
    elvl = (idle_mode == 2'b01);
  endtask

  task automatic t_ratio(input int hs, input int ls, input string req);
    int hi, lo, half, bad;
    hs_ratio = 10'(hs); ls_code = 3'(ls); out_en = 1'b1;
    half = (hs << ls) / 2;
    measure(hi, lo);
    chk(hi == half, {req, " high phase"}, hi, half);
    chk(lo == half, {req, " low phase"}, lo, half);
    bad = 0;
    repeat (40) begin
      if (!(pad_oe && pad_lvl == div_clk)) bad++;
      step();
    end
    chk(bad == 0, {req, " pad follows divided clock"}, bad, 0);
  endtask

  task automatic t_squelch(input int settle, input string req);
    int bad;
    bit eoe, elvl;
    repeat (settle) step();
    idle_exp(eoe, elvl);
    bad = 0;
    repeat (40) begin
      if (div_clk || pad_oe !== eoe || pad_lvl !== elvl) bad++;
      step();
    end
    chk(bad == 0, {req, " squelched with divider halted"}, bad, 0);
  endtask

  task automatic t_idle_only(input string req);
    int bad;
    bit eoe, elvl;
    repeat (30) step();
    idle_exp(eoe, elvl);
    bad = 0;
    repeat (30) begin
      if (pad_oe !== eoe || pad_lvl !== elvl) bad++;
      step();
    end
    chk(bad == 0, {req, " idle pad state"}, bad, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_mode = 2'b10;
    repeat (3) step();
    chk(pad_oe && !pad_lvl && !div_clk, "R9 reset drives low", {pad_oe, pad_lvl, div_clk}, 3'b100);
    idle_mode = 2'b00;
    step();
    chk(!pad_oe && !div_clk, "R9 reset high-Z", {pad_oe, div_clk}, 0);
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_modes();
    out_en = 1'b0; hs_ratio = 10'd10; ls_code = 3'd0;
    idle_mode = 2'b00; t_idle_only("R5 mode 00");
    idle_mode = 2'b10; t_idle_only("R5 mode 10");
    idle_mode = 2'b01; t_idle_only("R5 mode 01");
    idle_mode = 2'b11; t_idle_only("R5 mode 11 reserved");
  endtask

  task automatic t_illegal();
    int hi, lo;
    idle_mode = 2'b01;
    hs_ratio = 10'd11; t_squelch(40, "R2 odd ratio");
    hs_ratio = 10'd8;  t_squelch(5, "R2 ratio below 10");
    hs_ratio = 10'd10; ls_code = 3'd6; t_squelch(40, "R3 code 110");
    ls_code = 3'd7; t_squelch(5, "R3 code 111");
    hs_ratio = 10'd20; ls_code = 3'd1; grade_min = 16'd40; grade_max = 16'd40;
    measure(hi, lo);
    chk(hi == 20 && lo == 20, "R4 inclusive window runs", hi, 20);
    grade_min = 16'd41; t_squelch(80, "R4 below grade_min");
    grade_min = 16'd0; grade_max = 16'd39; t_squelch(5, "R4 above grade_max");
    grade_max = 16'hFFFF;
  endtask

  task automatic t_enable();
    int hi, lo;
    idle_mode = 2'b01; hs_ratio = 10'd10; ls_code = 3'd0;
    out_en = 1'b0; t_idle_only("R6 enable cleared");
    out_en = 1'b1; t_ratio(10, 0, "R6 resume after enable");
    cal_busy = 1'b1; t_idle_only("R6 calibration busy");
    cal_busy = 1'b0; measure(hi, lo);
    chk(hi == 5 && pad_oe, "R6 resume after calibration", hi, 5);
  endtask

  task automatic t_gate();
    int hi, lo, n;
    idle_mode = 2'b00; hs_ratio = 10'd10; ls_code = 3'd2; out_en = 1'b1;
    measure(hi, lo);
    n = 0;
    repeat (3) begin if (pad_oe && pad_lvl) n++; step(); end
    out_en = 1'b0;
    while (pad_oe && pad_lvl) begin n++; step(); end
    chk(n == 20, "R7 high phase completes before squelch", n, 20);
    chk(!pad_oe, "R7 squelch at period end", pad_oe, 0);
    repeat (7) step();
    out_en = 1'b1;
    while (!pad_oe) step();
    chk(!pad_lvl, "R7 live output starts low", pad_lvl, 0);
    n = 0;
    while (pad_oe && !pad_lvl) begin n++; step(); end
    chk(n == 20, "R7 first low phase full", n, 20);
  endtask

  task automatic t_switch();
    int hi, lo, n;
    idle_mode = 2'b00; hs_ratio = 10'd10; ls_code = 3'd0; out_en = 1'b1;
    measure(hi, lo);
    n = 0;
    repeat (2) begin n++; step(); end
    hs_ratio = 10'd20;
    while (div_clk) begin n++; step(); end
    chk(n == 5, "R8 current high phase unchanged", n, 5);
    lo = 0; while (!div_clk) begin lo++; step(); end
    hi = 0; while (div_clk) begin hi++; step(); end
    chk(lo == 10 && hi == 10, "R8 new ratio from period end", lo + hi, 20);
  endtask

  task automatic t_collide();
    int hi, lo, n;
    idle_mode = 2'b00; hs_ratio = 10'd10; ls_code = 3'd0; out_en = 1'b1;
    measure(hi, lo);
    n = 0;
    repeat (2) begin if (pad_oe && pad_lvl) n++; step(); end
    hs_ratio = 10'd20; out_en = 1'b0;
    while (pad_oe && pad_lvl) begin n++; step(); end
    chk(n == 5 && !pad_oe, "R7 R8 reload and squelch together", n, 5);
    out_en = 1'b1;
    while (!pad_oe) step();
    lo = 0; while (pad_oe && !pad_lvl) begin lo++; step(); end
    hi = 0; while (pad_oe && pad_lvl) begin hi++; step(); end
    chk(lo == 10 && hi == 10, "R8 collision resumes at new ratio", lo + hi, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hs_ratio = 10'd10; ls_code = 3'd0; out_en = 1'b0; idle_mode = 2'b00;
    grade_min = 16'd0; grade_max = 16'hFFFF; cal_busy = 1'b0; rst_n = 1'b0;
    t_reset();
    t_modes();
    t_ratio(1022, 0, "R2 R1 ratio 1022");
    t_ratio(12, 2, "R1 ratio 12 code 010");
    t_ratio(14, 5, "R1 ratio 14 code 101");
    t_ratio(10, 0, "R1 ratio 10 code 000");
    t_illegal();
    t_enable();
    t_gate();
    t_switch();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule